// File: doc/BRIEF.md
# Signed-Digit Karatsuba Multiplier

This block multiplies two signed-digit operands and returns a signed-digit product. Each operand has N digits. Every digit is carried on two wires: a plus component and a minus component. The digit's value is plus minus minus, so both wires high means zero. Because of this, one integer has many legal encodings. Every addition inside the block is carry-free. Each carry moves at most two digit positions, so the logic depth of an addition does not grow with the operand width.

The product is built by Karatsuba splitting, applied recursively down to a 2-digit base multiplier.
- Each operand is cut into a low half and a high half.
- Three half-size multipliers form the products of the low halves, of the high halves, and of the two half sums.
- A half sum needs one digit more than a half. That extra top digit is taken off before the middle multiplier. Its effect is added back from shifted, sign-selected copies of the other half sum, so all three sub-multipliers stay balanced.

The product is registered once, so it appears one clock after the operands are presented. It is a 2N-digit signed-digit vector. Its weighted value equals the true product modulo 2^(2N), as with any truncated redundant result. A later conversion stage resolves this.

Top module: `sd_kara_mul`

## Requirements
- R1: Operand digit i has weight 2^i and value pos[i] − neg[i]. The operand value is the weighted sum of its digits.
- R2: One clock after the operands are sampled, the output digit sum Σ(p_pos[i] − p_neg[i])·2^i is congruent to A·B modulo 2^(2N). If the operands stay unchanged from one cycle to the next, the output bits also stay unchanged.
- R3: While rst_n is low, p_pos and p_neg are all zero.
- R4: Different encodings of the same two integers give output values congruent to the same product.
- R5: With N = 8, operands of value 85 and 59 give a product of value 5015.
- R6: Operands whose half sums carry a top digit of +1 or −1 give the correct product. The cases include all digits +1, all digits −1, and mixed signs.
- R7: A digit with both components set counts as zero. An operand made only of such digits gives a zero product.
- R8: If either operand has value zero, the product value is zero.
- R9: Negative operand values give products with the correct sign, modulo 2^(2N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_pos | input | N | Plus components of operand A |
| a_neg | input | N | Minus components of operand A |
| b_pos | input | N | Plus components of operand B |
| b_neg | input | N | Minus components of operand B |
| p_pos | output | 2N | Plus components of the product |
| p_neg | output | 2N | Minus components of the product |

## Verification
The block holds only one register stage, so any error in the splitting, the carry-digit correction or the recombination shows up at the output one clock after the operands that trigger it. Such an error is visible as a wrong product value modulo 2^(2N). Carry-digit errors appear only when a half sum overflows, so the stimulus drives all-plus, all-minus and mixed-sign operands. Redundant encodings, including digits with both components set, are checked to give the same product as plain binary encodings of the same integers.

// File: rtl/sd_kara_core.sv
module sd_kara_core #(
  parameter int N  = 8,
  parameter int OW = 16
) (
  input  logic [N-1:0]  ap,
  input  logic [N-1:0]  an,
  input  logic [N-1:0]  bp,
  input  logic [N-1:0]  bn,
  output logic [OW-1:0] pp,
  output logic [OW-1:0] pn
);

  // carry-free signed-digit add, two full-adder layers, result mod 2^OW
  function automatic logic [2*OW-1:0] sd_add(input logic [OW-1:0] xp, xn, yp, yn);
    logic [OW-1:0] s1, m1, c1, s2, m2, c2;
    s1 = xp ^ yp ^ ~xn;
    m1 = (xp & yp) | (xp & ~xn) | (yp & ~xn);
    c1 = {m1[OW-2:0], 1'b1};
    s2 = s1 ^ c1 ^ ~yn;
    m2 = (s1 & c1) | (s1 & ~yn) | (c1 & ~yn);
    c2 = {m2[OW-2:0], 1'b0};
    return {c2, ~s2};
  endfunction

  function automatic logic [1:0] dmul(input logic xp, xn, yp, yn);
    return {(xp & yp) | (xn & yn), (xp & yn) | (xn & yp)};
  endfunction

  generate
    if (N == 2) begin : g_base
      logic d00p, d00n, d01p, d01n, d10p, d10n, d11p, d11n;
      logic [OW-1:0] xp, xn, yp, yn, zp, zn, tp, tn;
      assign {d00p, d00n} = dmul(ap[0], an[0], bp[0], bn[0]);
      assign {d01p, d01n} = dmul(ap[0], an[0], bp[1], bn[1]);
      assign {d10p, d10n} = dmul(ap[1], an[1], bp[0], bn[0]);
      assign {d11p, d11n} = dmul(ap[1], an[1], bp[1], bn[1]);
      assign xp = OW'({d11p, 1'b0, d00p});
      assign xn = OW'({d11n, 1'b0, d00n});
      assign yp = OW'({d01p, 1'b0});
      assign yn = OW'({d01n, 1'b0});
      assign zp = OW'({d10p, 1'b0});
      assign zn = OW'({d10n, 1'b0});
      assign {tp, tn} = sd_add(xp, xn, yp, yn);
      assign {pp, pn} = sd_add(tp, tn, zp, zn);
    end else begin : g_split
      localparam int H = N / 2;
      logic [OW-1:0] sap, san, tbp, tbn;
      logic [OW-1:0] lop, lon, hip, hin, mdp, mdn;
      logic [OW-1:0] ctp, ctn, csp, csn, up, un;
      logic [OW-1:0] m1p, m1n, m2p, m2n, m3p, m3n, m4p, m4n, r1p, r1n;
      logic [H-1:0]  sp, sn, tp, tn;
      logic          cap, can, cbp, cbn, ccp, ccn;

      assign {sap, san} = sd_add(OW'(ap[H-1:0]), OW'(an[H-1:0]), OW'(ap[N-1:H]), OW'(an[N-1:H]));
      assign {tbp, tbn} = sd_add(OW'(bp[H-1:0]), OW'(bn[H-1:0]), OW'(bp[N-1:H]), OW'(bn[N-1:H]));
      assign sp = sap[H-1:0];
      assign sn = san[H-1:0];
      assign tp = tbp[H-1:0];
      assign tn = tbn[H-1:0];
      assign {cap, can} = {sap[H], san[H]};
      assign {cbp, cbn} = {tbp[H], tbn[H]};

      sd_kara_core #(.N(H), .OW(OW)) u_lo (
        .ap(ap[H-1:0]), .an(an[H-1:0]), .bp(bp[H-1:0]), .bn(bn[H-1:0]), .pp(lop), .pn(lon));
      sd_kara_core #(.N(H), .OW(OW)) u_hi (
        .ap(ap[N-1:H]), .an(an[N-1:H]), .bp(bp[N-1:H]), .bn(bn[N-1:H]), .pp(hip), .pn(hin));
      sd_kara_core #(.N(H), .OW(OW)) u_md (
        .ap(sp), .an(sn), .bp(tp), .bn(tn), .pp(mdp), .pn(mdn));

      // stripped carry digits: ca*t' + cb*s' at 2^H, ca*cb at 2^N
      assign ctp = OW'(({H{cap}} & tp) | ({H{can}} & tn));
      assign ctn = OW'(({H{cap}} & tn) | ({H{can}} & tp));
      assign csp = OW'(({H{cbp}} & sp) | ({H{cbn}} & sn));
      assign csn = OW'(({H{cbp}} & sn) | ({H{cbn}} & sp));
      assign {up, un}   = sd_add(ctp, ctn, csp, csn);
      assign {ccp, ccn} = dmul(cap, can, cbp, cbn);

      assign {m1p, m1n} = sd_add(mdp, mdn, up << H, un << H);
      assign {m2p, m2n} = sd_add(m1p, m1n, OW'(ccp) << N, OW'(ccn) << N);
      assign {m3p, m3n} = sd_add(m2p, m2n, hin, hip);
      assign {m4p, m4n} = sd_add(m3p, m3n, lon, lop);
      assign {r1p, r1n} = sd_add(lop, lon, hip << N, hin << N);
      assign {pp, pn}   = sd_add(r1p, r1n, m4p << H, m4n << H);

      // R6: the half sums hold no value above their carry digit
      always_comb begin
        if (!$isunknown({ap, an, bp, bn}))
          a_r6_halfsum_fits: assert ((sap[OW-1:H+1] ^ san[OW-1:H+1]) == '0 &&
                                     (tbp[OW-1:H+1] ^ tbn[OW-1:H+1]) == '0)
            else $error("half sum spills above its carry digit");
      end
    end
  endgenerate

endmodule

// File: rtl/sd_kara_mul.sv
module sd_kara_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a_pos,
  input  logic [N-1:0]   a_neg,
  input  logic [N-1:0]   b_pos,
  input  logic [N-1:0]   b_neg,
  output logic [2*N-1:0] p_pos,
  output logic [2*N-1:0] p_neg
);

  localparam int W2 = 2 * N;

  logic [W2-1:0] cp, cn;

  sd_kara_core #(.N(N), .OW(W2)) u_core (
    .ap(a_pos), .an(a_neg), .bp(b_pos), .bn(b_neg), .pp(cp), .pn(cn));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_pos <= '0;
      p_neg <= '0;
    end else begin
      p_pos <= cp;
      p_neg <= cn;
    end

  logic [W2-1:0] av, bv, pv;
  assign av = W2'(a_pos) - W2'(a_neg);
  assign bv = W2'(b_pos) - W2'(b_neg);
  assign pv = p_pos - p_neg;

  a_r3_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (p_pos == '0 && p_neg == '0));

  a_r2_product_mod: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pv == W2'($past(av) * $past(bv)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable({a_pos, a_neg, b_pos, b_neg})) |=> $stable({p_pos, p_neg}));

  a_r8_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(av) == '0 || $past(bv) == '0)) |-> pv == '0);

endmodule

// File: tb/tb_sd_kara_mul.sv
`timescale 1ns/1ps
module tb_sd_kara_mul;
  localparam int N = 8;
  localparam longint MOD = 64'd1 << (2 * N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] a_pos = '0, a_neg = '0, b_pos = '0, b_neg = '0;
  logic [2*N-1:0] p_pos, p_neg;
  int total = 0, bad = 0;
  longint exp_q[$];

  sd_kara_mul #(.N(N)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic longint sdv(input logic [63:0] p, input logic [63:0] n, input int w);
    longint v = 0;
    for (int i = 0; i < w; i++) v += (longint'(p[i]) - longint'(n[i])) * (64'sd1 <<< i);
    return v;
  endfunction

  function automatic longint md(input longint v);
    return ((v % MOD) + MOD) % MOD;
  endfunction

  task automatic note(input bit ok, input string req, input longint got, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // drive at a falling edge; the product is checked at the next falling edge
  task automatic go(input logic [N-1:0] ap, an, bp, bn, input string req);
    longint e, g;
    a_pos = ap; a_neg = an; b_pos = bp; b_neg = bn;
    e = sdv(64'(ap), 64'(an), N) * sdv(64'(bp), 64'(bn), N);
    @(negedge clk);
    g = sdv(64'(p_pos), 64'(p_neg), 2 * N);
    note(md(g) == md(e), req, md(g), md(e));
  endtask

  task automatic mkrep(input int v, output logic [N-1:0] p, output logic [N-1:0] n);
    int k;
    logic [N-1:0] z;
    if (v >= 0) begin k = $urandom_range(255 - v, 0); p = N'(v + k); n = N'(k); end
    else begin k = $urandom_range(255 + v, 0); n = N'(-v + k); p = N'(k); end
    z = ~(p | n) & N'($urandom);
    p |= z; n |= z;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL R2 watchdog got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] p1, n1, p2, n2;
    logic [2*N-1:0] hp, hn;
    repeat (3) @(negedge clk);
    note(p_pos == '0 && p_neg == '0, "R3 reset", longint'({p_pos, p_neg}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    go(8'd85, 8'd0, 8'd59, 8'd0, "R5 85*59");
    go(8'd85, 8'd0, 8'd59, 8'd0, "R5 85*59 again");
    mkrep(85, p1, n1); mkrep(59, p2, n2);
    go(p1, n1, p2, n2, "R4 85*59 redundant");
    mkrep(85, p1, n1); mkrep(59, p2, n2);
    go(p1, n1, p2, n2, "R4 85*59 second encoding");
    go(8'hFF, 8'h00, 8'hFF, 8'h00, "R6 all plus");
    go(8'h00, 8'hFF, 8'h00, 8'hFF, "R6 all minus");
    go(8'hFF, 8'h00, 8'h00, 8'hFF, "R6 R9 plus times minus");
    go(8'hF0, 8'h0F, 8'h0F, 8'hF0, "R6 R9 mixed halves");
    go(8'h00, 8'h0F, 8'hF0, 8'h00, "R6 R9 negative carry");
    go(8'hFF, 8'hFF, 8'h5A, 8'h21, "R7 both set digits");
    go(8'h00, 8'h00, 8'hC3, 8'h18, "R8 zero operand");
    mkrep(-100, p1, n1); mkrep(77, p2, n2);
    go(p1, n1, p2, n2, "R9 negative redundant");
    mkrep(-255, p1, n1); mkrep(-255, p2, n2);
    go(p1, n1, p2, n2, "R9 both extreme negative");

    // R2 hold: same inputs, output bits must not move
    go(8'h3C, 8'h81, 8'h7E, 8'h05, "R2 hold setup");
    hp = p_pos; hn = p_neg;
    @(negedge clk);
    note(p_pos == hp && p_neg == hn, "R2 hold", longint'({p_pos, p_neg}), longint'({hp, hn}));

    for (int i = 0; i < 300; i++)
      go(N'($urandom), N'($urandom), N'($urandom), N'($urandom), "R1 R2 random");
    for (int i = 0; i < 100; i++) begin
      int va = $urandom_range(510, 0) - 255;
      int vb = $urandom_range(510, 0) - 255;
      mkrep(va, p1, n1); mkrep(vb, p2, n2);
      go(p1, n1, p2, n2, "R4 random redundant");
    end

    rst_n = 1'b0;
    #1;
    note(p_pos == '0 && p_neg == '0, "R3 reset mid run", longint'({p_pos, p_neg}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    go(8'd85, 8'd0, 8'd59, 8'd0, "R5 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule